// File: doc/BRIEF.md
# Scheduler Delta Syntonizer

This block produces the delta strobe for a time-triggered schedule engine. The engine runs from raw oscillator ticks, and a nominal delta is 25 ticks. The same oscillator also feeds a time-of-day counter, but a servo speeds that counter up or slows it down. Left alone, the delta stream drifts away from the corrected time. The block removes that drift. Over each correction period it compares the advance of the corrected time with the number of raw ticks that passed, and it holds the difference as a signed residual. On the delta boundaries that follow, it pays the residual back by shortening or stretching deltas by whole ticks.

Each delta moves by at most 5 ticks. A delta therefore lies between 20 and 30 ticks, which keeps the slew within 5 ticks per 20. Any residual still unpaid when a period closes carries into the next period. When the residual at a period close is larger than one period can absorb, the block raises a flag. A step in the time-of-day value cannot be absorbed. Software stops the engine, which clears the state, and then restarts it so that measurement begins again from the current time.

Top module: `tick_syntonizer`

## Requirements
- R1: While disabled, the strobe comes exactly every 25 ticks, whatever the time-of-day input does. After reset the first strobe is sampled on the 25th rising edge after reset is released.
- R2: While enabled, with the time-of-day advancing by one per tick, every delta stays at 25 ticks and the flag stays low.
- R3: The enable is sampled high on some edge. On that edge, and again on each edge that closes a period, the block records the current time-of-day as the start of a new period. A period closes on the first edge where the time-of-day minus that recorded start is at least the period length input. The drift measured at that edge is the time-of-day elapsed minus the raw ticks elapsed.
- R4: A positive residual shortens the deltas that follow, and a negative one stretches them. Each delta changes from 25 by no more than 5 ticks, so every delta is between 20 and 30 ticks.
- R5: Each delta consumes up to 5 ticks of the residual. Once the residual reaches zero, deltas return to 25 ticks. The total change across all deltas equals the measured drift.
- R6: Residual not yet consumed when a period closes is kept. The new measurement is added to it.
- R7: The overflow flag updates only on edges that close a period. At that point it is set if |residual| × 25 > 5 × period length, and cleared otherwise. Equality does not set it. Between period closes the flag holds its value.
- R8: Dropping the enable clears the residual, the measurement and the flag. The delta loaded on that edge is 25 ticks. A time-of-day step made while disabled has no effect after the block is re-enabled.
- R9: If a period closes on the same edge as a delta strobe, that delta uses the residual from before the close. The new drift is still added in full, so it is paid back starting with the next delta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw scheduler tick clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Enables drift measurement and correction |
| tod_i | input | TOD_W | Corrected time-of-day, in scheduler tick units |
| period_len_i | input | PER_W | Correction period length, in time-of-day units |
| delta_stb_o | output | 1 | One-tick strobe that ends each delta |
| drift_ovf_o | output | 1 | Residual at the last period close exceeded one period's correction budget |

## Verification
Two events can fall on the same edge: a delta strobe, which consumes residual, and a period close, which adds newly measured drift to the residual. The bench forces them to coincide. It enables the block exactly on a strobe edge, injects 4 ticks of fast time-of-day, and sets a period length of 104. The period then closes on the fourth strobe edge. The bench judges the result from the delta lengths. The delta loaded on the shared edge must be 25 ticks, the next one must be 21, and the total shortening must be 4. Any ordering of the two updates that drops or double-applies one of them breaks this sequence.

// File: rtl/tsyn_pkg.sv
`timescale 1ns/1ps
package tsyn_pkg;
  parameter int RES_W = 16;
  typedef logic signed [RES_W-1:0] res_t;

  // Per-delta correction: residual limited to +/- lim ticks
  function automatic res_t clamp_step(res_t r, int lim);
    if (r > lim)  return res_t'(lim);
    if (r < -lim) return res_t'(-lim);
    return r;
  endfunction

  // a - b + c with symmetric saturation
  function automatic res_t sat_add3(res_t a, res_t b, res_t c);
    logic signed [RES_W+1:0] s;
    int top;
    top = 2 ** (RES_W - 1) - 1;
    s = (RES_W+2)'(a) - (RES_W+2)'(b) + (RES_W+2)'(c);
    if (s > top)  return res_t'(top);
    if (s < -top) return res_t'(-top);
    return res_t'(s);
  endfunction

  function automatic logic [RES_W-1:0] mag(res_t r);
    return r[RES_W-1] ? RES_W'(-r) : RES_W'(r);
  endfunction

  // Residual larger than what one period of deltas can absorb
  function automatic logic over_budget(res_t r, int nom, int lim, logic [39:0] per);
    return (40'(mag(r)) * 40'(nom)) > (40'(lim) * per);
  endfunction
endpackage

// File: rtl/tsyn_delta_gen.sv
`timescale 1ns/1ps
module tsyn_delta_gen
  import tsyn_pkg::*;
#(
  parameter int NOM_TICKS = 25,
  parameter int MAX_ADJ   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  res_t adj_i,
  output logic stb_o
);
  localparam int LEN_MAX = NOM_TICKS + MAX_ADJ;
  localparam int CW      = $clog2(LEN_MAX + 1);

  logic [CW-1:0] dcnt_q;
  logic [CW-1:0] load_w;

  assign stb_o  = (dcnt_q == '0);
  assign load_w = CW'(NOM_TICKS - 1 - int'(adj_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    dcnt_q <= CW'(NOM_TICKS - 1);
    else if (stb_o) dcnt_q <= load_w;
    else            dcnt_q <= dcnt_q - 1'b1;
  end
endmodule

// File: rtl/tsyn_meter.sv
`timescale 1ns/1ps
module tsyn_meter
  import tsyn_pkg::*;
#(
  parameter int TOD_W = 32,
  parameter int PER_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TOD_W-1:0] tod_i,
  input  logic [PER_W-1:0] per_i,
  output logic             pend_o,
  output res_t             drift_o
);
  logic             run_q;
  logic [TOD_W-1:0] start_q;
  logic [RES_W-1:0] ticks_q;
  logic [TOD_W-1:0] elapsed_w;

  assign elapsed_w = tod_i - start_q;
  assign pend_o    = run_q && (elapsed_w >= TOD_W'(per_i));
  // Modular difference of low bits is exact while |drift| < 2^(RES_W-1)
  assign drift_o   = res_t'(elapsed_w[RES_W-1:0] - ticks_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      start_q <= '0;
      ticks_q <= '0;
    end else if (!en_i) begin
      run_q   <= 1'b0;
      ticks_q <= '0;
    end else if (!run_q || pend_o) begin
      run_q   <= 1'b1;
      start_q <= tod_i;
      ticks_q <= RES_W'(1);
    end else begin
      ticks_q <= ticks_q + 1'b1;
    end
  end
endmodule

// File: rtl/tsyn_resid.sv
`timescale 1ns/1ps
module tsyn_resid
  import tsyn_pkg::*;
#(
  parameter int NOM_TICKS = 25,
  parameter int MAX_ADJ   = 5,
  parameter int PER_W     = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             pend_i,
  input  res_t             drift_i,
  input  logic [PER_W-1:0] per_i,
  output res_t             adj_o,
  output logic             ovf_o
);
  res_t resid_q;
  res_t take_w;
  res_t resid_d;

  assign take_w  = en_i ? clamp_step(resid_q, MAX_ADJ) : '0;
  assign adj_o   = take_w;
  assign resid_d = sat_add3(resid_q, stb_i ? take_w : '0, pend_i ? drift_i : '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      resid_q <= '0;
      ovf_o   <= 1'b0;
    end else begin
      resid_q <= resid_d;
      if (pend_i) ovf_o <= over_budget(resid_d, NOM_TICKS, MAX_ADJ, 40'(per_i));
    end
  end

  AST_RESID_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stb_i && !pend_i) |=> (mag(resid_q) <= $past(mag(resid_q)))); // R5
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pend_i) |=> $stable(ovf_o)); // R7
endmodule

// File: rtl/tick_syntonizer.sv
`timescale 1ns/1ps
module tick_syntonizer
  import tsyn_pkg::*;
#(
  parameter int NOM_TICKS = 25,
  parameter int MAX_ADJ   = 5,
  parameter int TOD_W     = 32,
  parameter int PER_W     = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TOD_W-1:0] tod_i,
  input  logic [PER_W-1:0] period_len_i,
  output logic             delta_stb_o,
  output logic             drift_ovf_o
);
  localparam int GW = $clog2(NOM_TICKS + MAX_ADJ + 2) + 1;

  logic pend_w;
  res_t drift_w;
  res_t adj_w;

  tsyn_meter #(.TOD_W(TOD_W), .PER_W(PER_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tod_i(tod_i),
    .per_i(period_len_i), .pend_o(pend_w), .drift_o(drift_w)
  );

  tsyn_resid #(.NOM_TICKS(NOM_TICKS), .MAX_ADJ(MAX_ADJ), .PER_W(PER_W)) u_resid (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .stb_i(delta_stb_o),
    .pend_i(pend_w), .drift_i(drift_w), .per_i(period_len_i),
    .adj_o(adj_w), .ovf_o(drift_ovf_o)
  );

  tsyn_delta_gen #(.NOM_TICKS(NOM_TICKS), .MAX_ADJ(MAX_ADJ)) u_delta (
    .clk_i(clk_i), .rst_ni(rst_ni), .adj_i(adj_w), .stb_o(delta_stb_o)
  );

  // Independent gap measurement for the slew checks
  logic [GW-1:0] gap_q;
  logic          dis_load_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gap_q      <= GW'(1);
      dis_load_q <= 1'b1;
    end else if (delta_stb_o) begin
      gap_q      <= GW'(1);
      dis_load_q <= !en_i;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_SLEW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta_stb_o |-> (gap_q >= GW'(NOM_TICKS - MAX_ADJ) && gap_q <= GW'(NOM_TICKS + MAX_ADJ))); // R4
  AST_DISABLED_NOMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delta_stb_o && dis_load_q) |-> (gap_q == GW'(NOM_TICKS))); // R1
endmodule

// File: tb/tick_syntonizer_bench.sv
`timescale 1ns/1ps
module tick_syntonizer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] tod = '0;
  logic [23:0] per = 24'd100;
  int          tod_step = 1;
  wire         stb;
  wire         ovf;

  int checks = 0;
  int fails = 0;
  bit ovf_seen = 0;
  bit done = 0;
  int gaps [32];

  always #2.5 clk = ~clk;

  tick_syntonizer u_tick_syntonizer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tod_i(tod),
    .period_len_i(per), .delta_stb_o(stb), .drift_ovf_o(ovf)
  );

  initial forever begin
    @(posedge clk);
    #1;
    tod = tod + 32'(tod_step);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_gap(input int start, output int g);
    g = start;
    do begin
      @(negedge clk);
      g++;
      if (ovf) ovf_seen = 1;
    end while (!stb);
  endtask

  // Disable, resync to a strobe, enable on the strobe edge
  task automatic arm(input int p);
    int g;
    en = 0;
    tod_step = 1;
    per = 24'(p);
    for (int i = 0; i < 3; i++) next_gap(0, g);
    ovf_seen = 0;
    en = 1;
  endtask

  // step != 1 for d cycles right after enable, then collect n gaps
  task automatic drift_run(input int p, input int step, input int d, input int n);
    int g;
    arm(p);
    tod_step = step;
    repeat (d) @(negedge clk);
    tod_step = 1;
    next_gap(d, g);
    gaps[0] = g;
    for (int i = 1; i < n; i++) begin
      next_gap(0, g);
      gaps[i] = g;
    end
  endtask

  function automatic int shortening(input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += 25 - gaps[i];
    return s;
  endfunction

  function automatic int first_dev(input int n);
    for (int i = 0; i < n; i++) if (gaps[i] != 25) return gaps[i];
    return 25;
  endfunction

  task automatic t_reset();
    int g;
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(stb == 0, "R1 reset strobe", int'(stb), 0);
    chk(ovf == 0, "R7 reset flag", int'(ovf), 0);
    rst_n = 1;
    next_gap(0, g);
    chk(g == 24, "R1 first strobe after reset", g, 24);
  endtask

  task automatic t_disabled();
    int g;
    en = 0;
    tod_step = 3;
    next_gap(0, g);
    for (int i = 0; i < 5; i++) begin
      next_gap(0, g);
      chk(g == 25, "R1 disabled delta", g, 25);
    end
    chk(ovf == 0, "R1 disabled flag", int'(ovf), 0);
    tod_step = 1;
  endtask

  task automatic t_locked();
    drift_run(100, 1, 0, 12);
    for (int i = 0; i < 12; i++) chk(gaps[i] == 25, "R2 locked delta", gaps[i], 25);
    chk(ovf_seen == 0, "R2 no flag", int'(ovf_seen), 0);
  endtask

  task automatic t_fast();
    drift_run(200, 2, 7, 16);
    chk(shortening(16) == 7, "R5 total shortening", shortening(16), 7);
    chk(first_dev(16) == 20, "R4 first corrected delta", first_dev(16), 20);
    chk(gaps[8] == 20 && gaps[9] == 23, "R3 correction starts after close", gaps[9], 23);
    chk(ovf_seen == 0, "R7 small drift no flag", int'(ovf_seen), 0);
  endtask

  task automatic t_slow();
    drift_run(200, 0, 12, 16);
    chk(shortening(16) == -12, "R5 total stretching", shortening(16), -12);
    chk(first_dev(16) == 30, "R4 stretch limited to 30", first_dev(16), 30);
    chk(gaps[11] == 27 && gaps[12] == 25, "R5 back to nominal", gaps[11], 27);
  endtask

  task automatic t_carry();
    drift_run(40, 2, 14, 12);
    chk(shortening(12) == 14, "R6 residual carried", shortening(12), 14);
    chk(gaps[2] == 20 && gaps[3] == 20 && gaps[4] == 21, "R6 spread over periods", gaps[4], 21);
    chk(ovf_seen == 1, "R7 flag set", int'(ovf_seen), 1);
    chk(ovf == 0, "R7 flag cleared at later close", int'(ovf), 0);
  endtask

  task automatic t_edge();
    drift_run(70, 2, 14, 10);
    chk(ovf_seen == 0, "R7 equality no flag", int'(ovf_seen), 0);
    chk(shortening(10) == 14, "R5 edge total", shortening(10), 14);
    drift_run(69, 2, 14, 4);
    chk(ovf_seen == 1, "R7 just over budget", int'(ovf_seen), 1);
  endtask

  task automatic t_coincide();
    drift_run(104, 2, 4, 10);
    chk(gaps[4] == 25, "R9 coincident delta uses old residual", gaps[4], 25);
    chk(gaps[5] == 21, "R9 drift kept on coincidence", gaps[5], 21);
    chk(shortening(10) == 4, "R3 drift measured", shortening(10), 4);
  endtask

  task automatic t_restart();
    int g;
    arm(40);
    tod_step = 2;
    repeat (14) @(negedge clk);
    tod_step = 1;
    next_gap(14, g);
    next_gap(0, g);
    chk(ovf == 1, "R7 flag before disable", int'(ovf), 1);
    en = 0;
    @(negedge clk);
    chk(ovf == 0, "R8 disable clears flag", int'(ovf), 0);
    for (int i = 0; i < 3; i++) begin
      next_gap((i == 0) ? 1 : 0, g);
      chk(g == 25, "R8 nominal after disable", g, 25);
    end
    tod_step = 500;
    repeat (3) @(negedge clk);
    tod_step = 1;
    arm(100);
    for (int i = 0; i < 10; i++) begin
      next_gap(0, g);
      chk(g == 25, "R8 no stale residual after restart", g, 25);
    end
    chk(ovf_seen == 0, "R8 no flag after restart", int'(ovf_seen), 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_locked();
    t_fast();
    t_slow();
    t_carry();
    t_edge();
    t_coincide();
    t_restart();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule